// File: doc/BRIEF.md
# Two-Stage Load-Balanced Cell Switch

This block is an N-port cell switch that never computes a match. It has two stages, and each follows a fixed rotating pattern. In every cell slot, stage one hands each arriving cell to an intermediate port chosen only by the input number and the slot number. The cell's destination plays no part in that choice. Each intermediate port keeps one queue per final output. Stage two rotates the same way and lets each intermediate port send the head of one of its queues to one output.

The switch needs no request/grant exchange and no central arbiter. The price is that cells from one input can travel through different intermediate ports and reach an output out of order. The block does not restore order. It stamps each cell with a per-input sequence number, and each output flags a cell that arrives behind an earlier one from the same input.

Queue overflow drops the arriving cell and counts the drop in a saturating counter per queue.

Top module: `lb_cell_switch`

## Requirements
- R1: While `rst_n` is low, every `out_valid` and `out_misorder` bit is 0 and every drop counter reads 0. All queues start empty, and the first slot after reset is slot 0.
- R2: The slot number t counts clock cycles after reset modulo N. In slot t, a valid cell at input i goes to intermediate port (i+t) mod N, into that port's queue for its `in_dest`, whatever the destination is. `out_src` carries i.
- R3: In slot t, intermediate port k serves its queue for output j=(k+t) mod N. The head cell appears on output j's fields after the clock edge that ends slot t, with its payload unchanged. A cell that enters a queue in slot t can leave no earlier than slot t+1.
- R4: If the queue selected for an output in a slot is empty, that output shows `out_valid`=0 with zero fields for that slot. No other queue is served in its place.
- R5: Each queue delivers its cells in the order they were accepted.
- R6: A cell that arrives at a queue holding DEPTH cells at the start of the slot is discarded. The counter for queue (k,d) then rises by 1 and saturates at all ones. This counter sits at bits [(k*N+d)*CW +: CW] of `drop_cnt`. An accepted cell leaves the counter unchanged.
- R7: Each input keeps an SW-bit sequence counter. It starts at 0 after reset and advances by 1 for every valid arriving cell, including dropped cells. The value before the advance travels with the cell on `out_seq`.
- R8: `out_misorder` is high, together with `out_valid`, when the output has already delivered a cell from the same `out_src` since reset and the SW-bit value (new seq − last seq) is zero or has its top bit set. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cell slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Cell present at each input |
| in_dest | input | N*LW | Destination output per input, must be below N |
| in_data | input | N*DW | Cell payload per input |
| out_valid | output | N | Cell present at each output |
| out_src | output | N*LW | Input the delivered cell came from |
| out_seq | output | N*SW | Sequence stamp of the delivered cell |
| out_data | output | N*DW | Payload of the delivered cell |
| out_misorder | output | N | Delivered cell is behind an earlier one from the same input |
| drop_cnt | output | N*N*CW | Saturating drop counter per intermediate queue |

## Verification
The embedded properties assume that every `in_dest` value names a real output below N. They also assume that inputs change only between clock edges. Under those assumptions, a queue's fill can never pass DEPTH, a drop counter moves by at most one per slot, and the flag and idle fields line up with `out_valid`.

The stimulus draws destinations only in 0..N-1 and drives inputs on the falling edge. It mixes single sparse cells, uniform random traffic and a long all-to-one hotspot. The hotspot both overflows and saturates counters and produces reordering, and the run ends with an idle drain that empties every queue.

// File: rtl/lb_cell_switch.sv
module lb_cell_switch #(
  parameter int N     = 4,
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int SW    = 6,
  parameter int CW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      in_valid,
  input  logic [N*((N>1)?$clog2(N):1)-1:0] in_dest,
  input  logic [N*DW-1:0]   in_data,
  output logic [N-1:0]      out_valid,
  output logic [N*((N>1)?$clog2(N):1)-1:0] out_src,
  output logic [N*SW-1:0]   out_seq,
  output logic [N*DW-1:0]   out_data,
  output logic [N-1:0]      out_misorder,
  output logic [N*N*CW-1:0] drop_cnt
);
  localparam int LW = (N > 1) ? $clog2(N) : 1;
  localparam int QN = N * N;
  localparam int QW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = DW + LW + SW;

  function automatic int wrapn(input int v);
    return (v >= N) ? v - N : v;
  endfunction

  logic [LW-1:0] slot;
  logic [EW-1:0] mem [QN][DEPTH];
  logic [PW-1:0] wp [QN];
  logic [PW-1:0] rp [QN];
  logic [QW-1:0] cnt [QN];
  logic [CW-1:0] drops [QN];
  logic [SW-1:0] seq_ctr [N];
  logic [SW-1:0] last [N][N];
  logic          seen [N][N];

  logic [QN-1:0] push, pop, ovf;
  logic [EW-1:0] push_ent [QN];
  logic [EW-1:0] hd [N];
  logic [LW-1:0] hsrc [N];
  logic [SW-1:0] hdiff [N];
  logic [N-1:0]  hv, hm;

  // stage one: input (k - t) mod N feeds intermediate k
  always_comb begin
    push = '0;
    ovf  = '0;
    for (int q = 0; q < QN; q++) push_ent[q] = '0;
    for (int k = 0; k < N; k++) begin
      int i;
      int q;
      i = wrapn(k + N - int'(slot));
      q = k * N + int'(in_dest[i*LW +: LW]);
      if (in_valid[i]) begin
        if (cnt[q] != QW'(DEPTH)) begin
          push[q]     = 1'b1;
          push_ent[q] = {in_data[i*DW +: DW], LW'(i), seq_ctr[i]};
        end else begin
          ovf[q] = 1'b1;
        end
      end
    end
  end

  // stage two: intermediate (j - t) mod N serves output j
  always_comb begin
    pop = '0;
    for (int j = 0; j < N; j++) begin
      int k;
      int q;
      k = wrapn(j + N - int'(slot));
      q = k * N + j;
      hv[j]    = (cnt[q] != '0);
      pop[q]   = hv[j];
      hd[j]    = hv[j] ? mem[q][rp[q]] : '0;
      hsrc[j]  = hd[j][SW +: LW];
      hdiff[j] = hd[j][SW-1:0] - last[j][hsrc[j]];
      hm[j]    = hv[j] && seen[j][hsrc[j]] &&
                 ((hdiff[j] == '0) || hdiff[j][SW-1]);
    end
  end

  always_ff @(posedge clk) begin
    for (int q = 0; q < QN; q++)
      if (push[q]) mem[q][wp[q]] <= push_ent[q];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot         <= '0;
      out_valid    <= '0;
      out_src      <= '0;
      out_seq      <= '0;
      out_data     <= '0;
      out_misorder <= '0;
      for (int q = 0; q < QN; q++) begin
        wp[q] <= '0; rp[q] <= '0; cnt[q] <= '0; drops[q] <= '0;
      end
      for (int i = 0; i < N; i++) begin
        seq_ctr[i] <= '0;
        for (int s = 0; s < N; s++) begin
          last[i][s] <= '0;
          seen[i][s] <= 1'b0;
        end
      end
    end else begin
      slot <= (slot == LW'(N-1)) ? '0 : slot + 1'b1;
      for (int q = 0; q < QN; q++) begin
        if (push[q]) wp[q] <= (wp[q] == PW'(DEPTH-1)) ? '0 : wp[q] + 1'b1;
        if (pop[q])  rp[q] <= (rp[q] == PW'(DEPTH-1)) ? '0 : rp[q] + 1'b1;
        cnt[q] <= cnt[q] + QW'(push[q]) - QW'(pop[q]);
        if (ovf[q] && drops[q] != '1) drops[q] <= drops[q] + 1'b1;
      end
      for (int i = 0; i < N; i++)
        seq_ctr[i] <= seq_ctr[i] + SW'(in_valid[i]);
      for (int j = 0; j < N; j++) begin
        out_valid[j]         <= hv[j];
        out_misorder[j]      <= hm[j];
        out_seq[j*SW +: SW]  <= hd[j][SW-1:0];
        out_src[j*LW +: LW]  <= hsrc[j];
        out_data[j*DW +: DW] <= hd[j][SW+LW +: DW];
        if (hv[j]) begin
          seen[j][hsrc[j]] <= 1'b1;
          last[j][hsrc[j]] <= hd[j][SW-1:0];
        end
      end
    end
  end

  for (genvar g = 0; g < QN; g++) begin : g_drop
    assign drop_cnt[g*CW +: CW] = drops[g];

    // R6
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] <= QW'(DEPTH));

    // R6
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (drops[g] == $past(drops[g])) || (drops[g] == $past(drops[g]) + 1'b1));
  end

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> slot == (($past(slot) == LW'(N-1)) ? '0 : $past(slot) + 1'b1));

  // R8
  flag_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_misorder & ~out_valid) == '0);

  for (genvar g = 0; g < N; g++) begin : g_idle
    // R4
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid[g] |-> (out_data[g*DW +: DW] == '0 && out_seq[g*SW +: SW] == '0));
  end
endmodule

// File: tb/lb_cell_switch_tb.sv
module lb_cell_switch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4, DEPTH = 4, DW = 8, SW = 6, CW = 4;
  localparam int LW = 2;
  localparam int QN = N * N;
  localparam int EW = DW + LW + SW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] in_valid = '0;
  logic [N*LW-1:0] in_dest = '0;
  logic [N*DW-1:0] in_data = '0;
  logic [N-1:0] out_valid, out_misorder;
  logic [N*LW-1:0] out_src;
  logic [N*SW-1:0] out_seq;
  logic [N*DW-1:0] out_data;
  logic [QN*CW-1:0] drop_cnt;

  lb_cell_switch #(.N(N), .DEPTH(DEPTH), .DW(DW), .SW(SW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_src(out_src),
    .out_seq(out_seq), .out_data(out_data), .out_misorder(out_misorder),
    .drop_cnt(drop_cnt));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit run = 0, done = 0;
  int bslot = 0;

  logic [EW-1:0] mq [QN][$];
  logic [EW+1:0] expq [N][$];
  logic [SW-1:0] mseq [N];
  logic [SW-1:0] mlast [N][N];
  bit            mseen [N][N];
  int            mdrop [QN];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model of one slot, then wait for the next falling edge
  task automatic drive_slot(input logic [N-1:0] v, input logic [N*LW-1:0] d);
    logic [N*DW-1:0] dat;
    bit full [QN];
    for (int i = 0; i < N; i++) dat[i*DW +: DW] = DW'($urandom);
    in_valid = v; in_dest = d; in_data = dat;
    for (int q = 0; q < QN; q++) full[q] = (mq[q].size() == DEPTH);
    for (int j = 0; j < N; j++) begin
      int k, q;
      k = (j - bslot + N) % N;
      q = k * N + j;
      if (mq[q].size() > 0) begin
        logic [EW-1:0] e;
        logic [LW-1:0] s;
        logic [SW-1:0] df;
        bit mis;
        e = mq[q].pop_front();
        s = e[SW +: LW];
        df = e[SW-1:0] - mlast[j][s];
        mis = mseen[j][s] && (df == 0 || df[SW-1]);
        mseen[j][s] = 1; mlast[j][s] = e[SW-1:0];
        expq[j].push_back({1'b1, mis, e});
      end else begin
        expq[j].push_back('0);
      end
    end
    for (int i = 0; i < N; i++) if (v[i]) begin
      int q;
      q = ((i + bslot) % N) * N + int'(d[i*LW +: LW]);
      if (full[q]) begin
        if (mdrop[q] < (1 << CW) - 1) mdrop[q]++;
      end else begin
        mq[q].push_back({dat[i*DW +: DW], LW'(i), mseq[i]});
      end
      mseq[i]++;
    end
    bslot = (bslot + 1) % N;
    @(negedge clk);
  endtask

  // monitor: compare each output after the edge that ends a slot
  initial forever begin
    @(posedge clk); #1;
    if (run) for (int j = 0; j < N; j++) begin
      logic [EW+1:0] x;
      if (expq[j].size() == 0) continue;
      x = expq[j].pop_front();
      chk(out_valid[j] == x[EW+1], "R4", $sformatf("valid out%0d", j), out_valid[j], x[EW+1]);
      chk(out_misorder[j] == x[EW], "R8", $sformatf("misorder out%0d", j), out_misorder[j], x[EW]);
      if (x[EW+1]) begin
        chk(out_src[j*LW +: LW] == x[SW +: LW], "R2", $sformatf("src out%0d", j),
            out_src[j*LW +: LW], x[SW +: LW]);
        chk(out_seq[j*SW +: SW] == x[SW-1:0], "R7", $sformatf("seq out%0d", j),
            out_seq[j*SW +: SW], x[SW-1:0]);
        // R3 R5: payload and per-queue order
        chk(out_data[j*DW +: DW] == x[SW+LW +: DW], "R3", $sformatf("data out%0d", j),
            out_data[j*DW +: DW], x[SW+LW +: DW]);
      end
    end
  end

  task automatic check_drops(input string tag);
    for (int q = 0; q < QN; q++)
      chk(int'(drop_cnt[q*CW +: CW]) == mdrop[q], "R6",
          $sformatf("%s drop q%0d", tag, q), drop_cnt[q*CW +: CW], mdrop[q]);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog run did not end");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mseq[i] = '0;
      for (int s = 0; s < N; s++) begin mlast[i][s] = '0; mseen[i][s] = 0; end
    end
    for (int q = 0; q < QN; q++) mdrop[q] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == '0, "R1", "valid in reset", out_valid, 0);
    chk(out_misorder == '0, "R1", "flag in reset", out_misorder, 0);
    chk(drop_cnt == '0, "R1", "drops in reset", 0, 0);
    rst_n = 1'b1;
    run = 1;
    // R2 R3 sparse: input 0 -> dest 2 in slot 0, input 3 -> dest 0 in slot 1
    drive_slot(4'b0001, {2'd0, 2'd0, 2'd0, 2'd2});
    drive_slot(4'b1000, {2'd0, 2'd0, 2'd0, 2'd0});
    repeat (6) drive_slot('0, '0);
    // uniform random traffic
    for (int n = 0; n < 200; n++) begin
      logic [N*LW-1:0] d;
      for (int i = 0; i < N; i++) d[i*LW +: LW] = LW'($urandom % N);
      drive_slot(N'($urandom), d);
    end
    // R6 R8 hotspot: every input to output 1
    for (int n = 0; n < 80; n++) drive_slot('1, {2'd1, 2'd1, 2'd1, 2'd1});
    check_drops("hotspot");
    // R4 drain: idle slots empty every queue
    repeat (30) drive_slot('0, '0);
    for (int j = 0; j < N; j++)
      chk(out_valid[j] == 1'b0, "R4", $sformatf("drained out%0d", j), out_valid[j], 0);
    check_drops("final");
    finish_run();
  end
endmodule